// File: doc/BRIEF.md
# Deferred Power-Down Controller for a Timer Engine

This block sits beside a multi-channel timer-processing engine and decides when the engine may be frozen to save power. A host sets a disable bit through a small register bus. The controller does not cut the engine off at once. It waits for a thread-busy signal from the engine to drop, so that a running thread always completes, and only then pulls the engine clock-enable low. While frozen, the two free-running time bases hold their counts and the input-pin sampling register keeps its last capture.

The host side stays awake the whole time. The host can still read and write the interrupt enables and clear interrupt flags while the engine is frozen. The host learns that the handshake has finished by polling a read-only halted bit. The block also merges the per-channel data-transfer requests into a single DMA request line.

Top module: `engine_stop_ctrl`

## Requirements
- R1: Writing 1 to bit 0 of the control register (address 0) records a disable request, and the bit reads back as written. Bit 1 of the same register is the read-only halted status.
- R2: While the thread-busy input is high, the engine clock-enable stays high and the halted bit stays 0, even if a disable request is pending. The halt begins on the first clock edge at which busy is seen low.
- R3: A disable request that arrives while the engine is idle halts it on the next clock edge. From then on `eng_clk_en` reads 0 and control bit 1 reads 1.
- R4: Time base 1 (address 3) increments once per running cycle. Time base 2 (address 4) increments once every `TB2_DIV` running cycles. While the engine is halted, both hold their values.
- R5: `pin_sampled` captures `pin_in` on every running cycle and keeps its last value while the engine is halted.
- R6: The interrupt-enable register (address 2) can be written and read back while the engine is halted.
- R7: Interrupt flags (address 1) are set by `chan_irq_set` pulses and cleared by writing 1 to them; writing 0 leaves a flag unchanged, and this works while the engine is halted. `irq_out` is the OR of the flags masked by the enables.
- R8: `dma_req` is the OR of all `chan_dma_req` bits, in the same cycle.
- R9: Clearing bit 0 ends the halt on the next clock edge. The counters then resume from their held values, gaining their first increment one edge later.
- R10: Reset clears the disable bit, both time bases, the interrupt flags and enables, and the sampled pins, and leaves `eng_clk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_thread_busy | input | 1 | High while the engine executes a thread |
| eng_clk_en | output | 1 | Engine clock-enable |
| chan_irq_set | input | NUM_CH | Per-channel interrupt set pulses |
| chan_dma_req | input | NUM_CH | Per-channel data-transfer requests |
| pin_in | input | NUM_CH | Raw channel input pins |
| pin_sampled | output | NUM_CH | Sampled pin register |
| tb1_value | output | TB_W | Time base 1 |
| tb2_value | output | TB_W | Time base 2 |
| irq_out | output | 1 | Combined, enabled interrupt |
| dma_req | output | 1 | Combined DMA request |

## Verification
Read data and `dma_req` are combinational, so the bench checks them 1 ns after driving at a falling edge. A register write takes effect at the rising edge that follows the write strobe. The halt or restart comes one edge after that, and counters and pin captures react one edge later still. Every check is sampled at a falling edge that the bench has counted out against those stages. The halt entry is sampled twice, at the falling edge just after the write and at the next one, which pins down the exact cycle.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRAIN = 2'd1,
      ST_HALT  = 2'd2
   } halt_state_e;

   localparam int unsigned REG_ADDR_W = 3;
   localparam int unsigned BUS_W      = 32;

   localparam logic [REG_ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [REG_ADDR_W-1:0] A_FLAG = 3'd1;
   localparam logic [REG_ADDR_W-1:0] A_IEN  = 3'd2;
   localparam logic [REG_ADDR_W-1:0] A_TB1  = 3'd3;
   localparam logic [REG_ADDR_W-1:0] A_TB2  = 3'd4;
   localparam logic [REG_ADDR_W-1:0] A_PIN  = 3'd5;

   localparam int unsigned CTRL_DIS_BIT  = 0;
   localparam int unsigned CTRL_HALT_BIT = 1;
endpackage

// File: rtl/esc_halt_fsm.sv
module esc_halt_fsm
   import esc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dis_req,
   input  logic thread_busy,
   output logic eng_run,
   output logic halted
);
   halt_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (dis_req) state_d = thread_busy ? ST_DRAIN : ST_HALT;
         end
         ST_DRAIN: begin
            if (!dis_req)         state_d = ST_RUN;
            else if (!thread_busy) state_d = ST_HALT;
         end
         ST_HALT: begin
            if (!dis_req) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign halted  = (state_q == ST_HALT);
   assign eng_run = !halted;

   AST_NO_MIDTHREAD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && thread_busy) |=> !halted); // R2
   AST_IDLE_HALT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_req && !thread_busy && !halted) |=> halted); // R3
   AST_RESTART_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !dis_req) |=> eng_run); // R9
endmodule

// File: rtl/esc_timebase.sv
module esc_timebase #(
   parameter int unsigned TB_W   = 24,
   parameter int unsigned TB2_DIV = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   output logic [TB_W-1:0] tb1,
   output logic [TB_W-1:0] tb2
);
   localparam int unsigned PRE_W = (TB2_DIV > 1) ? $clog2(TB2_DIV) : 1;

   if (TB_W < 2 || TB_W > 32) begin : g_bad_width
      $error("esc_timebase: TB_W must lie in 2..32");
   end
   if (TB2_DIV < 1) begin : g_bad_div
      $error("esc_timebase: TB2_DIV must be at least 1");
   end

   logic            tb2_step;
   logic [TB_W-1:0] tb1_q, tb2_q;

   if (TB2_DIV == 1) begin : g_nodiv
      assign tb2_step = tick_en;
   end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pre_q <= '0;
         else if (tick_en) begin
            if (pre_q == PRE_W'(TB2_DIV - 1)) pre_q <= '0;
            else                              pre_q <= pre_q + 1'b1;
         end
      end
      assign tb2_step = tick_en && (pre_q == PRE_W'(TB2_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb1_q <= '0;
         tb2_q <= '0;
      end else begin
         if (tick_en)  tb1_q <= tb1_q + 1'b1;
         if (tb2_step) tb2_q <= tb2_q + 1'b1;
      end
   end

   assign tb1 = tb1_q;
   assign tb2 = tb2_q;

   AST_TB1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(tb1_q)); // R4
   AST_TB2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(tb2_q)); // R4
   AST_TB1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (tb1_q == $past(tb1_q) + 1'b1)); // R4
endmodule

// File: rtl/esc_pin_sampler.sv
module esc_pin_sampler #(
   parameter int unsigned PIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [PIN_W-1:0] pins,
   output logic [PIN_W-1:0] pins_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pins_q <= '0;
      else if (sample_en) pins_q <= pins;
   end

   AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(pins_q)); // R5
endmodule

// File: rtl/esc_irq_bank.sv
module esc_irq_bank #(
   parameter int unsigned NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] clr_mask,
   input  logic              en_we,
   input  logic [NUM_CH-1:0] en_wdata,
   output logic [NUM_CH-1:0] flags,
   output logic [NUM_CH-1:0] enables,
   output logic              irq
);
   logic [NUM_CH-1:0] flag_q, en_q, clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         en_q   <= '0;
      end else begin
         flag_q <= (flag_q & ~clr_eff) | set_i;
         if (en_we) en_q <= en_wdata;
      end
   end

   assign flags   = flag_q;
   assign enables = en_q;
   assign irq     = |(flag_q & en_q);

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && (set_i == '0)) |=> ((flag_q & $past(clr_mask)) == '0)); // R7
   AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we) |=> ((flag_q & ~$past(clr_mask)) == ($past(flag_q) & ~$past(clr_mask))
                    | ($past(set_i) & ~$past(clr_mask)))); // R7
   AST_IEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> (en_q == $past(en_wdata))); // R6
endmodule

// File: rtl/engine_stop_ctrl.sv
module engine_stop_ctrl
   import esc_pkg::*;
#(
   parameter int unsigned NUM_CH  = 32,
   parameter int unsigned TB_W    = 24,
   parameter int unsigned TB2_DIV = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic                  eng_thread_busy,
   output logic                  eng_clk_en,
   input  logic [NUM_CH-1:0]     chan_irq_set,
   input  logic [NUM_CH-1:0]     chan_dma_req,
   input  logic [NUM_CH-1:0]     pin_in,
   output logic [NUM_CH-1:0]     pin_sampled,
   output logic [TB_W-1:0]       tb1_value,
   output logic [TB_W-1:0]       tb2_value,
   output logic                  irq_out,
   output logic                  dma_req
);
   if (NUM_CH < 1 || NUM_CH > BUS_W) begin : g_bad_ch
      $error("engine_stop_ctrl: NUM_CH must lie in 1..32");
   end

   logic              dis_q;
   logic              eng_run, halted;
   logic              wr_ctrl, wr_flag, wr_ien;
   logic [NUM_CH-1:0] flags, enables;

   assign wr_ctrl = bus_sel && bus_we && (bus_addr == A_CTRL);
   assign wr_flag = bus_sel && bus_we && (bus_addr == A_FLAG);
   assign wr_ien  = bus_sel && bus_we && (bus_addr == A_IEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dis_q <= 1'b0;
      else if (wr_ctrl) dis_q <= bus_wdata[CTRL_DIS_BIT];
   end

   esc_halt_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .dis_req     (dis_q),
      .thread_busy (eng_thread_busy),
      .eng_run     (eng_run),
      .halted      (halted)
   );

   esc_timebase #(.TB_W(TB_W), .TB2_DIV(TB2_DIV)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (eng_run),
      .tb1     (tb1_value),
      .tb2     (tb2_value)
   );

   esc_pin_sampler #(.PIN_W(NUM_CH)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (eng_run),
      .pins      (pin_in),
      .pins_q    (pin_sampled)
   );

   esc_irq_bank #(.NUM_CH(NUM_CH)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (chan_irq_set),
      .clr_we   (wr_flag),
      .clr_mask (bus_wdata[NUM_CH-1:0]),
      .en_we    (wr_ien),
      .en_wdata (bus_wdata[NUM_CH-1:0]),
      .flags    (flags),
      .enables  (enables),
      .irq      (irq_out)
   );

   assign eng_clk_en = eng_run;
   assign dma_req    = |chan_dma_req;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[CTRL_DIS_BIT]  = dis_q;
            bus_rdata[CTRL_HALT_BIT] = halted;
         end
         A_FLAG:  bus_rdata[NUM_CH-1:0] = flags;
         A_IEN:   bus_rdata[NUM_CH-1:0] = enables;
         A_TB1:   bus_rdata[TB_W-1:0]   = tb1_value;
         A_TB2:   bus_rdata[TB_W-1:0]   = tb2_value;
         A_PIN:   bus_rdata[NUM_CH-1:0] = pin_sampled;
         default: bus_rdata = '0;
      endcase
   end

   AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (dis_q == $past(bus_wdata[CTRL_DIS_BIT]))); // R1
   AST_HALT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!dis_q && !halted) |=> !halted); // R3
endmodule

// File: tb/engine_stop_ctrl_tb.sv
module engine_stop_ctrl_tb;
   localparam int unsigned NCH = 32;
   localparam int unsigned TBW = 24;
   localparam int unsigned DIV = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            busy = 1'b0;
   logic            eng_clk_en;
   logic [NCH-1:0]  irq_set = '0, dma_in = '0, pins = '0, pins_q;
   logic [TBW-1:0]  tb1, tb2;
   logic            irq_out, dma_req;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   engine_stop_ctrl #(.NUM_CH(NCH), .TB_W(TBW), .TB2_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_thread_busy(busy), .eng_clk_en(eng_clk_en),
      .chan_irq_set(irq_set), .chan_dma_req(dma_in), .pin_in(pins),
      .pin_sampled(pins_q), .tb1_value(tb1), .tb2_value(tb2),
      .irq_out(irq_out), .dma_req(dma_req)
   );

   // dma pattern, expected combined request
   localparam logic [32:0] DMA_VEC [8] = '{
      {32'h0000_0000, 1'b0}, {32'h0000_0001, 1'b1}, {32'h8000_0000, 1'b1},
      {32'h0001_0000, 1'b1}, {32'hFFFF_FFFF, 1'b1}, {32'h0000_0000, 1'b0},
      {32'h0F00_00F0, 1'b1}, {32'h0000_0000, 1'b0}};

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, a1, a2, b1, b2, h1, h2;
      logic [31:0] pa, pb;
      pa = 32'hA5C3_0F11;
      pb = 32'h5A3C_F0EE;

      // R10 reset state
      @(negedge clk); @(negedge clk);
      rd(3'd3, v); chk(v == 0, "R10 tb1", v, 0);
      rd(3'd0, v); chk(v == 0, "R10 ctrl", v, 0);
      rd(3'd1, v); chk(v == 0, "R10 flags", v, 0);
      chk(eng_clk_en == 1'b1, "R10 clk_en", 32'(eng_clk_en), 1);
      rst_n = 1'b1;

      // R8 table walk
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         dma_in = DMA_VEC[i][32:1];
         #1 chk(dma_req == DMA_VEC[i][0], "R8 dma_or", 32'(dma_req), 32'(DMA_VEC[i][0]));
      end
      dma_in = '0;

      // R4 running rates
      @(negedge clk);
      rd(3'd3, a1); rd(3'd4, a2);
      repeat (12) @(negedge clk);
      rd(3'd3, b1); rd(3'd4, b2);
      chk(b1 - a1 == 12, "R4 tb1 rate", b1 - a1, 12);
      chk(b2 - a2 == 3, "R4 tb2 rate", b2 - a2, 3);

      // R5 running capture, R7 flag set
      pins = pa;
      irq_set = 32'h5;
      @(negedge clk);
      irq_set = '0;
      chk(pins_q == pa, "R5 capture", pins_q, pa);
      rd(3'd1, v); chk(v == 32'h5, "R7 flag set", v, 5);

      // R1 / R3 idle halt
      busy = 1'b0;
      wr(3'd0, 32'h1);
      chk(eng_clk_en == 1'b1, "R3 not before next edge", 32'(eng_clk_en), 1);
      rd(3'd0, v); chk(v == 32'h1, "R1 ctrl readback", v, 1);
      @(negedge clk);
      chk(eng_clk_en == 1'b0, "R3 clk_en low", 32'(eng_clk_en), 0);
      rd(3'd0, v); chk(v == 32'h3, "R3 halted bit", v, 3);

      // R4 / R5 hold while halted
      rd(3'd3, h1); rd(3'd4, h2);
      pins = pb;
      repeat (6) @(negedge clk);
      rd(3'd3, v); chk(v == h1, "R4 tb1 held", v, h1);
      rd(3'd4, v); chk(v == h2, "R4 tb2 held", v, h2);
      chk(pins_q == pa, "R5 pins held", pins_q, pa);

      // R6 / R7 register file live while halted
      wr(3'd2, 32'h0F);
      rd(3'd2, v); chk(v == 32'h0F, "R6 ien readback", v, 32'h0F);
      chk(irq_out == 1'b1, "R7 irq_out", 32'(irq_out), 1);
      wr(3'd1, 32'h1);
      rd(3'd1, v); chk(v == 32'h4, "R7 w1c partial", v, 4);
      chk(irq_out == 1'b1, "R7 irq still", 32'(irq_out), 1);
      wr(3'd1, 32'h4);
      rd(3'd1, v); chk(v == 32'h0, "R7 w1c rest", v, 0);
      chk(irq_out == 1'b0, "R7 irq off", 32'(irq_out), 0);
      chk(eng_clk_en == 1'b0, "R6 still halted", 32'(eng_clk_en), 0);

      // R9 restart
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk(v == 32'h2, "R9 ctrl before restart", v, 2);
      @(negedge clk);
      chk(eng_clk_en == 1'b1, "R9 clk_en back", 32'(eng_clk_en), 1);
      rd(3'd3, v); chk(v == h1, "R9 tb1 resumes held", v, h1);
      @(negedge clk);
      rd(3'd3, v); chk(v == h1 + 1, "R9 tb1 first step", v, h1 + 1);
      chk(pins_q == pb, "R5 sampling resumed", pins_q, pb);

      // R2 deferred halt
      busy = 1'b1;
      wr(3'd0, 32'h1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(eng_clk_en == 1'b1, "R2 busy keeps running", 32'(eng_clk_en), 1);
         rd(3'd0, v); chk(v == 32'h1, "R2 no halted bit", v, 1);
      end
      busy = 1'b0;
      @(negedge clk);
      chk(eng_clk_en == 1'b0, "R2 halt after thread", 32'(eng_clk_en), 0);
      rd(3'd0, v); chk(v == 32'h3, "R2 halted bit", v, 3);
      wr(3'd0, 32'h0);
      @(negedge clk);
      chk(eng_clk_en == 1'b1, "R9 second restart", 32'(eng_clk_en), 1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule